// File: doc/BRIEF.md
# Lockable Configuration Register Bank

This block is a small bank of 32-bit control words on a simple word-addressed bus. The bus has a write strobe and a combinational read port. One configuration word drives two mapping-swap controls and an update-pending flag. A read-only status word shows which swaps are actually in force. Six spare words hold application data. The spares form three pairs, and each pair is cleared by a different reset domain: system, external or power-on.

Protection has two levels and is set per register. Each protected word has a lock bit, and a locked word drops bus writes without any error. Each lock bit also has a commit bit. A commit bit can only be set. Once it is set, the matching lock bit is frozen until the next system reset. Writes to the configuration and spare words also need the write-protect enable input to be high. The memory-pair swap is held off, and hidden in the status word, while the security-mismatch input is high.

Each reset input is asserted asynchronously. Its release is taken through a two-stage synchronizer.

Top module: `cfg_lock_bank`

## Requirements
- R1: While or after the system reset is asserted, the configuration, status, lock and commit words all read 0, and pair_swap, vec_swap and upd_pending are 0.
- R2: Word offsets are decoded as follows: 0x00 configuration, 0x02 status, 0x10 + 2k spare k (k = 0..5), 0x1C lock, 0x1E commit. Any other offset reads 0 and ignores writes. Spare k is also visible on spare_q[32k+31:32k].
- R3: Configuration bit 20 drives pair_swap, bit 12 drives vec_swap and bit 0 drives upd_pending. All other configuration bits read 0.
- R4: A write to the configuration word or a spare word takes effect only when wp_open is 1 in the write cycle.
- R5: Lock bit 0 guards the configuration word. Lock bit 8+k guards spare k. A write to a guarded word is dropped, and reads are never blocked.
- R6: The lock word can be written whatever the value of wp_open. Only bits 0 and 8..13 are stored, and all its other bits read 0.
- R7: Writing 1 to a commit bit (positions 0 and 8..13) sets it. Writing 0 has no effect, and only the system reset clears it. Other commit bits read 0.
- R8: A lock bit whose commit bit is set keeps its value on any lock-word write. Uncommitted lock bits still take the written value.
- R9: Status bit 20 reads as configuration bit 20 AND NOT sec_mismatch. Status bit 12 reads as configuration bit 12. Its other bits read 0, and writes to the status word are ignored. pair_swap is 0 while sec_mismatch is 1.
- R10: Spares 0–1 are cleared only by sys_rst_n, spares 2–3 only by ext_rst_n and spares 4–5 only by por_rst_n. Configuration, lock and commit are not cleared by ext_rst_n or por_rst_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sys_rst_n | input | 1 | System reset, active low, asynchronous |
| ext_rst_n | input | 1 | External reset, active low, clears spares 2–3 |
| por_rst_n | input | 1 | Power-on reset, active low, clears spares 4–5 |
| bus_addr | input | 5 | Word offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| wp_open | input | 1 | Write-protect enable for configuration and spare words |
| sec_mismatch | input | 1 | Blocks the memory-pair swap |
| pair_swap | output | 1 | Memory-pair swap in force |
| vec_swap | output | 1 | Alternate vector-table location selected |
| upd_pending | output | 1 | Update request pending |
| spare_q | output | 192 | Contents of the six spare words |

## Verification
The bench commits a lock bit while it is 0 and then writes all-ones to the lock word. A design that fails to freeze committed bits would lock the configuration word and drop the next configuration write. It also writes 0 to commit bits. A design that treats commit as an ordinary register would lose its protection. Each reset domain is pulsed on its own, and the bench checks that the other pairs keep their values; a swapped or shared domain wiring would clear the wrong spares. With sec_mismatch raised, the bench checks that the swap is hidden both from pair_swap and from the status word.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;
  localparam int unsigned DATA_W        = 32;
  localparam int unsigned ADDR_W        = 5;
  // word offsets
  localparam logic [ADDR_W-1:0] OFS_CFG    = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 5'h02;
  localparam logic [ADDR_W-1:0] OFS_SPARE0 = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_LOCK   = 5'h1C;
  localparam logic [ADDR_W-1:0] OFS_COMMIT = 5'h1E;
  // configuration bit positions
  localparam int unsigned BIT_PAIR_SWAP = 20;
  localparam int unsigned BIT_VEC_SWAP  = 12;
  localparam int unsigned BIT_UPD_PEND  = 0;
  // guard (lock / commit) bit positions
  localparam int unsigned GBIT_CFG      = 0;
  localparam int unsigned GBIT_SPARE0   = 8;
  // reset domains
  typedef enum logic [1:0] {DOM_SYS = 2'd0, DOM_EXT = 2'd1, DOM_POR = 2'd2} rst_dom_e;
  localparam int unsigned NUM_DOM = 3;
endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_out_n = sync_q[STAGES-1];
endmodule

// File: rtl/cfg_spare_reg.sv
module cfg_spare_reg #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] d;

  always_comb begin
    d = q;
    if (wr_en) d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/cfg_guard_regs.sv
module cfg_guard_regs #(
  parameter int unsigned WIDTH = 32,
  parameter logic [WIDTH-1:0] MASK = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock_wr,
  input  logic             commit_wr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] lock_q,
  output logic [WIDTH-1:0] commit_q
);
  logic [WIDTH-1:0] lock_d;
  logic [WIDTH-1:0] commit_d;

  always_comb begin
    lock_d   = lock_q;
    commit_d = commit_q;
    if (lock_wr)
      lock_d = (wdata & MASK & ~commit_q) | (lock_q & commit_q);
    if (commit_wr)
      commit_d = commit_q | (wdata & MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q   <= '0;
      commit_q <= '0;
    end else begin
      lock_q   <= lock_d;
      commit_q <= commit_d;
    end
  end
endmodule

// File: rtl/cfg_lock_bank.sv
module cfg_lock_bank
  import cfg_bank_pkg::*;
#(
  parameter int unsigned NUM_SPARE = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        sys_rst_n,
  input  logic                        ext_rst_n,
  input  logic                        por_rst_n,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_we,
  input  logic [DATA_W-1:0]           bus_wdata,
  output logic [DATA_W-1:0]           bus_rdata,
  input  logic                        wp_open,
  input  logic                        sec_mismatch,
  output logic                        pair_swap,
  output logic                        vec_swap,
  output logic                        upd_pending,
  output logic [NUM_SPARE*DATA_W-1:0] spare_q
);
  localparam int unsigned PER_DOM = NUM_SPARE / NUM_DOM;
  localparam int unsigned GUARD_W = GBIT_SPARE0 + NUM_SPARE;
  localparam int unsigned SPARE_END = OFS_SPARE0 + 2 * NUM_SPARE;

  function automatic logic [DATA_W-1:0] guard_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    m[GBIT_CFG] = 1'b1;
    for (int k = 0; k < NUM_SPARE; k++) m[GBIT_SPARE0 + k] = 1'b1;
    return m;
  endfunction
  localparam logic [DATA_W-1:0] GUARD_MASK = guard_mask();
  localparam logic [DATA_W-1:0] CFG_MASK =
    (DATA_W'(1) << BIT_PAIR_SWAP) | (DATA_W'(1) << BIT_VEC_SWAP) | (DATA_W'(1) << BIT_UPD_PEND);

  // reset synchronizers, one per domain
  logic [NUM_DOM-1:0] dom_rst_raw;
  logic [NUM_DOM-1:0] dom_rst_s;
  logic               sys_rst_s;
  assign dom_rst_raw[DOM_SYS] = sys_rst_n;
  assign dom_rst_raw[DOM_EXT] = ext_rst_n;
  assign dom_rst_raw[DOM_POR] = por_rst_n;

  for (genvar g = 0; g < NUM_DOM; g++) begin : g_sync
    cfg_rst_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk       (clk),
      .rst_in_n  (dom_rst_raw[g]),
      .rst_out_n (dom_rst_s[g])
    );
  end
  assign sys_rst_s = dom_rst_s[DOM_SYS];

  // address decode
  logic                 hit_cfg, hit_stat, hit_lock, hit_commit, hit_spare;
  logic [ADDR_W-1:0]    spare_ofs;
  logic [NUM_SPARE-1:0] spare_sel;

  always_comb begin
    hit_cfg    = (bus_addr == OFS_CFG);
    hit_stat   = (bus_addr == OFS_STAT);
    hit_lock   = (bus_addr == OFS_LOCK);
    hit_commit = (bus_addr == OFS_COMMIT);
    hit_spare  = (32'(bus_addr) >= 32'(OFS_SPARE0)) && (32'(bus_addr) < SPARE_END) && !bus_addr[0];
    spare_ofs  = bus_addr - OFS_SPARE0;
    spare_sel  = '0;
    for (int k = 0; k < NUM_SPARE; k++)
      spare_sel[k] = hit_spare && (32'(spare_ofs[ADDR_W-1:1]) == k);
  end

  // lock and commit
  logic [DATA_W-1:0] guard_lock;
  logic [DATA_W-1:0] guard_commit;

  cfg_guard_regs #(.WIDTH(DATA_W), .MASK(GUARD_MASK)) i_guard (
    .clk       (clk),
    .rst_n     (sys_rst_s),
    .lock_wr   (bus_we && hit_lock),
    .commit_wr (bus_we && hit_commit),
    .wdata     (bus_wdata),
    .lock_q    (guard_lock),
    .commit_q  (guard_commit)
  );

  // configuration word
  logic [DATA_W-1:0] cfg_d, cfg_q;
  logic              cfg_wr;

  assign cfg_wr = bus_we && hit_cfg && wp_open && !guard_lock[GBIT_CFG];

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_wr) cfg_d = bus_wdata & CFG_MASK;
  end

  always_ff @(posedge clk or negedge sys_rst_s) begin
    if (!sys_rst_s) cfg_q <= '0;
    else            cfg_q <= cfg_d;
  end

  // status view
  logic [DATA_W-1:0] stat_word;
  always_comb begin
    stat_word = '0;
    stat_word[BIT_PAIR_SWAP] = cfg_q[BIT_PAIR_SWAP] && !sec_mismatch;
    stat_word[BIT_VEC_SWAP]  = cfg_q[BIT_VEC_SWAP];
  end

  assign pair_swap   = stat_word[BIT_PAIR_SWAP];
  assign vec_swap    = cfg_q[BIT_VEC_SWAP];
  assign upd_pending = cfg_q[BIT_UPD_PEND];

  // spare words, paired per reset domain
  logic [DATA_W-1:0] spare_word [NUM_SPARE];

  for (genvar k = 0; k < NUM_SPARE; k++) begin : g_spare
    logic wr_k;
    assign wr_k = bus_we && spare_sel[k] && wp_open && !guard_lock[GBIT_SPARE0 + k];
    cfg_spare_reg #(.WIDTH(DATA_W)) i_spare (
      .clk   (clk),
      .rst_n (dom_rst_s[k / PER_DOM]),
      .wr_en (wr_k),
      .wdata (bus_wdata),
      .q     (spare_word[k])
    );
    assign spare_q[k*DATA_W +: DATA_W] = spare_word[k];
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (hit_cfg)    bus_rdata = cfg_q;
    if (hit_stat)   bus_rdata = stat_word;
    if (hit_lock)   bus_rdata = guard_lock;
    if (hit_commit) bus_rdata = guard_commit;
    for (int k = 0; k < NUM_SPARE; k++)
      if (spare_sel[k]) bus_rdata = spare_word[k];
  end

  logic unused_ok;
  assign unused_ok = ^{GUARD_W, spare_ofs[0]};
endmodule

// File: rtl/cfg_bank_chk.sv
module cfg_bank_chk
  import cfg_bank_pkg::*;
(
  input logic              clk,
  input logic              sys_rst_s,
  input logic              wp_open,
  input logic              sec_mismatch,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [DATA_W-1:0] lock_q,
  input logic [DATA_W-1:0] commit_q,
  input logic [DATA_W-1:0] cfg_q,
  input logic              pair_swap
);
  // R7
  commit_sticky_chk: assert property (@(posedge clk) disable iff (!sys_rst_s)
    (commit_q & $past(commit_q)) == $past(commit_q));

  // R8
  frozen_lock_chk: assert property (@(posedge clk) disable iff (!sys_rst_s)
    ((lock_q ^ $past(lock_q)) & $past(commit_q)) == '0);

  // R4
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!sys_rst_s)
    (!wp_open || lock_q[GBIT_CFG]) |=> $stable(cfg_q));

  // R9
  swap_gate_chk: assert property (@(posedge clk) disable iff (!sys_rst_s)
    sec_mismatch |-> !pair_swap);

  // R2
  odd_ofs_zero_chk: assert property (@(posedge clk) disable iff (!sys_rst_s)
    bus_addr[0] |-> (bus_rdata == '0));

  // R6
  lock_rsvd_chk: assert property (@(posedge clk) disable iff (!sys_rst_s)
    lock_q[GBIT_SPARE0-1:1] == '0);
endmodule

bind cfg_lock_bank cfg_bank_chk i_chk (
  .clk          (clk),
  .sys_rst_s    (sys_rst_s),
  .wp_open      (wp_open),
  .sec_mismatch (sec_mismatch),
  .bus_addr     (bus_addr),
  .bus_rdata    (bus_rdata),
  .lock_q       (guard_lock),
  .commit_q     (guard_commit),
  .cfg_q        (cfg_q),
  .pair_swap    (pair_swap)
);

// File: tb/test_cfg_lock_bank.sv
module test_cfg_lock_bank;
  logic         clk = 1'b0;
  logic         sys_rst_n, ext_rst_n, por_rst_n;
  logic [4:0]   bus_addr;
  logic         bus_we;
  logic [31:0]  bus_wdata;
  logic [31:0]  bus_rdata;
  logic         wp_open, sec_mismatch;
  logic         pair_swap, vec_swap, upd_pending;
  logic [191:0] spare_q;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  cfg_lock_bank i_cfg_lock_bank (
    .clk(clk), .sys_rst_n(sys_rst_n), .ext_rst_n(ext_rst_n), .por_rst_n(por_rst_n),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wp_open(wp_open), .sec_mismatch(sec_mismatch), .pair_swap(pair_swap),
    .vec_swap(vec_swap), .upd_pending(upd_pending), .spare_q(spare_q)
  );

  typedef struct packed {
    logic [4:0]  addr;
    logic        wp;
    logic [31:0] wdata;
    logic [31:0] expv;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{5'h00, 1'b1, 32'hFFFF_FFFF, 32'h0010_1001}, // R3 only implemented bits
    '{5'h00, 1'b0, 32'h0000_0000, 32'h0010_1001}, // R4 wp closed
    '{5'h00, 1'b1, 32'h0000_1000, 32'h0000_1000}, // R3
    '{5'h10, 1'b1, 32'hA5A5_0001, 32'hA5A5_0001}, // R2 spare0
    '{5'h12, 1'b0, 32'h1234_5678, 32'h0000_0000}, // R4 spare1
    '{5'h14, 1'b1, 32'hDEAD_BEEF, 32'hDEAD_BEEF}, // R2 spare2
    '{5'h16, 1'b1, 32'h0BAD_F00D, 32'h0BAD_F00D}, // R2 spare3
    '{5'h18, 1'b1, 32'hCAFE_0004, 32'hCAFE_0004}, // R2 spare4
    '{5'h1A, 1'b1, 32'h5555_AAAA, 32'h5555_AAAA}, // R2 spare5
    '{5'h04, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000}, // R2 reserved
    '{5'h02, 1'b1, 32'hFFFF_FFFF, 32'h0000_1000}, // R9 status write ignored
    '{5'h1C, 1'b0, 32'hFFFF_FFFF, 32'h0000_3F01}, // R6 lock, wp closed
    '{5'h10, 1'b1, 32'h0000_0000, 32'hA5A5_0001}, // R5 spare0 locked
    '{5'h00, 1'b1, 32'h0010_0001, 32'h0000_1000}, // R5 cfg locked
    '{5'h1C, 1'b0, 32'h0000_0000, 32'h0000_0000}, // R6 unlock
    '{5'h1E, 1'b0, 32'h0000_0101, 32'h0000_0101}, // R7 commit set
    '{5'h1E, 1'b0, 32'h0000_0000, 32'h0000_0101}, // R7 zero no effect
    '{5'h1C, 1'b0, 32'hFFFF_FFFF, 32'h0000_3E00}, // R8 committed bits frozen
    '{5'h00, 1'b1, 32'h0010_0001, 32'h0010_0001}, // R8 cfg still open
    '{5'h10, 1'b1, 32'h0000_0077, 32'h0000_0077}, // R8 spare0 still open
    '{5'h12, 1'b1, 32'h0000_0099, 32'h0000_0000}  // R5 spare1 locked
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, expv);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic wp);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1; wp_open = wp;
    @(negedge clk);
    bus_we = 1'b0; wp_open = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    #1 d = bus_rdata;
  endtask

  task automatic rchk(input string req, input logic [4:0] a, input logic [31:0] expv);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, expv);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    sys_rst_n = 1'b0; ext_rst_n = 1'b0; por_rst_n = 1'b0;
    bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; wp_open = 1'b0; sec_mismatch = 1'b0;
    repeat (3) @(negedge clk);
    sys_rst_n = 1'b1; ext_rst_n = 1'b1; por_rst_n = 1'b1;
    settle();

    // R1 reset state
    rchk("R1 cfg", 5'h00, 32'h0);
    rchk("R1 status", 5'h02, 32'h0);
    rchk("R1 lock", 5'h1C, 32'h0);
    rchk("R1 commit", 5'h1E, 32'h0);
    chk("R1 outputs", {29'h0, pair_swap, vec_swap, upd_pending}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] d;
      wr(VEC[i].addr, VEC[i].wdata, VEC[i].wp);
      rd(VEC[i].addr, d);
      chk($sformatf("vector %0d", i), d, VEC[i].expv);
    end

    // R3 outputs follow cfg 0x0010_0001
    chk("R3 outputs", {29'h0, pair_swap, vec_swap, upd_pending}, 32'h5);
    chk("R2 spare_q slice 0", spare_q[31:0], 32'h77);

    // R9 security mismatch
    sec_mismatch = 1'b1;
    rchk("R9 status masked", 5'h02, 32'h0);
    chk("R9 pair_swap masked", {31'h0, pair_swap}, 32'h0);
    rchk("R9 cfg kept", 5'h00, 32'h0010_0001);
    sec_mismatch = 1'b0;
    rchk("R9 status open", 5'h02, 32'h0010_0000);

    // R10 external reset domain
    @(negedge clk); ext_rst_n = 1'b0;
    rchk("R10 ext spare2", 5'h14, 32'h0);
    rchk("R10 ext spare3", 5'h16, 32'h0);
    rchk("R10 ext spare0 kept", 5'h10, 32'h77);
    rchk("R10 ext spare4 kept", 5'h18, 32'hCAFE_0004);
    ext_rst_n = 1'b1; settle();

    // R10 power-on reset domain
    @(negedge clk); por_rst_n = 1'b0;
    rchk("R10 por spare4", 5'h18, 32'h0);
    rchk("R10 por spare5", 5'h1A, 32'h0);
    rchk("R10 por spare0 kept", 5'h10, 32'h77);
    rchk("R10 por cfg kept", 5'h00, 32'h0010_0001);
    rchk("R10 por commit kept", 5'h1E, 32'h0000_0101);
    por_rst_n = 1'b1; settle();

    // R6 then system reset
    wr(5'h1C, 32'h0, 1'b0);
    rchk("R6 lock cleared", 5'h1C, 32'h0);
    wr(5'h14, 32'h22, 1'b1);
    @(negedge clk); sys_rst_n = 1'b0;
    rchk("R1 sys cfg", 5'h00, 32'h0);
    rchk("R1 sys commit", 5'h1E, 32'h0);
    rchk("R10 sys spare0", 5'h10, 32'h0);
    rchk("R10 sys spare2 kept", 5'h14, 32'h22);
    chk("R1 sys outputs", {29'h0, pair_swap, vec_swap, upd_pending}, 32'h0);
    sys_rst_n = 1'b1; settle();

    // R7 / R8 after reset
    wr(5'h1E, 32'hFFFF_FFFE, 1'b0);
    rchk("R7 commit mask", 5'h1E, 32'h0000_3F00);
    wr(5'h1C, 32'hFFFF_FFFF, 1'b0);
    rchk("R8 only bit0 free", 5'h1C, 32'h0000_0001);
    wr(5'h00, 32'h0000_1000, 1'b1);
    rchk("R5 cfg locked", 5'h00, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule